// File: doc/BRIEF.md
# GPIO controller with interrupts

A 32-pin general-purpose I/O block on a simple word-addressed register bus. Software drives pins through an output value register and an output-enable register, and reads the pad levels after a two-flop synchroniser. Every pin also has its own event detector. A 2-bit trigger code per pin selects low level, high level, rising edge or falling edge. A separate any-edge bit per pin overrides the trigger code and reacts to both edges.

Detected events are latched in a sticky event register, and software clears bits by writing ones to it. A mask register decides which latched events reach the two interrupt request lines. One line serves pins 0 to 15 and the other serves pins 16 to 31. Writes take effect on the rising clock edge. Reads are combinational from the addressed register.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: While reset is asserted, every register reads 0 and `pin_out`, `pin_oe`, `irq_lo` and `irq_hi` are all 0.
- R2: Writing word address 0x00 sets the output value register, which drives `pin_out`. Writing 0x04 sets the output-enable register, which drives `pin_oe` (1 = output). Both registers read back what was written.
- R3: Reading 0x08 returns the pad levels after two synchronising flops. A pad change made between two rising edges shows up in the read after the second following edge and not after the first.
- R4: The trigger codes are 0 = low level, 1 = high level, 2 = rising edge and 3 = falling edge. Pin n < 16 takes its code from register 0x0C, bits 2n+1:2n. Pin n ≥ 16 takes its code from register 0x10, bits 2(n−16)+1:2(n−16). Both registers read back what was written.
- R5: An edge is found by comparing the synchronised pad with its value one cycle earlier. A matching edge sets the pin's event bit, and the bit reads as 1 after the third rising edge that follows the pad change.
- R6: A level trigger sets the event bit on every cycle the level holds, so a clear has no effect while that level persists.
- R7: When bit n of the any-edge register (0x1C) is 1, pin n's trigger code is ignored and both rising and falling edges set its event bit.
- R8: The event register (0x18) clears each bit written as 1 and leaves bits written as 0 unchanged. If an event and a clear reach the same bit in one cycle, the event wins.
- R9: Event bits are set whatever the mask register (0x14) holds.
- R10: `irq_lo` is the OR over pins 0–15 of (event AND mask), and `irq_hi` is the same OR over pins 16–31. A mask bit of 1 enables that pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write enable, qualified by bus_sel |
| bus_addr | input | 5 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register |
| pad_in | input | 32 | Asynchronous pad levels |
| pin_out | output | 32 | Output value per pin |
| pin_oe | output | 32 | Output enable per pin |
| irq_lo | output | 1 | Interrupt request for pins 0–15 |
| irq_hi | output | 1 | Interrupt request for pins 16–31 |

## Verification
The bench walks every pin through all four trigger codes and through the any-edge override. This catches a code field placed at the wrong bit offset or in the wrong configuration register: the event would then appear on a neighbouring pin, or on none. It clears events while a level still holds. A design that let the clear win would show a level-triggered pin as idle even though its condition is still true. It also samples the pad read one cycle too early, to catch a synchroniser with a missing stage. Finally, it clears half of the event register and moves the mask between the two halves. A design with the two interrupt lines crossed, or with a clear that also hits bits written as zero, fails here.

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl #(
  parameter int NPINS = 32,
  parameter int AW    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_we,
  input  logic [AW-1:0]    bus_addr,
  input  logic [NPINS-1:0] bus_wdata,
  output logic [NPINS-1:0] bus_rdata,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  output logic             irq_lo,
  output logic             irq_hi
);
  localparam int HALF = NPINS / 2;
  localparam int IW   = AW - 2;

  logic [NPINS-1:0] dat_q, dir_q, cfg_lo_q, cfg_hi_q, msk_q, sts_q, any_q;
  logic [NPINS-1:0] sync1_q, sync2_q, prev_q, hit, clr;
  logic [IW-1:0]    idx;
  logic             wr;

  assign idx = bus_addr[AW-1:2];
  assign wr  = bus_sel & bus_we;
  assign clr = (wr && idx == IW'(6)) ? bus_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat_q    <= '0;
      dir_q    <= '0;
      cfg_lo_q <= '0;
      cfg_hi_q <= '0;
      msk_q    <= '0;
      any_q    <= '0;
    end else if (wr) begin
      case (idx)
        IW'(0): dat_q    <= bus_wdata;
        IW'(1): dir_q    <= bus_wdata;
        IW'(3): cfg_lo_q <= bus_wdata;
        IW'(4): cfg_hi_q <= bus_wdata;
        IW'(5): msk_q    <= bus_wdata;
        IW'(7): any_q    <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
      prev_q  <= '0;
      sts_q   <= '0;
    end else begin
      sync1_q <= pad_in;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
      sts_q   <= (sts_q & ~clr) | hit;
    end
  end

  for (genvar n = 0; n < NPINS; n++) begin : g_pin
    logic [1:0] cond;
    logic       s, p;
    if (n < HALF) begin : g_lo
      assign cond = cfg_lo_q[2*n +: 2];
    end else begin : g_hi
      assign cond = cfg_hi_q[2*(n-HALF) +: 2];
    end
    assign s = sync2_q[n];
    assign p = prev_q[n];
    assign hit[n] = any_q[n]       ? (s ^ p)  :
                    (cond == 2'd0) ? ~s       :
                    (cond == 2'd1) ? s        :
                    (cond == 2'd2) ? (s & ~p) : (~s & p);
  end

  always_comb begin
    case (idx)
      IW'(0):  bus_rdata = dat_q;
      IW'(1):  bus_rdata = dir_q;
      IW'(2):  bus_rdata = sync2_q;
      IW'(3):  bus_rdata = cfg_lo_q;
      IW'(4):  bus_rdata = cfg_hi_q;
      IW'(5):  bus_rdata = msk_q;
      IW'(6):  bus_rdata = sts_q;
      IW'(7):  bus_rdata = any_q;
      default: bus_rdata = '0;
    endcase
  end

  assign pin_out = dat_q;
  assign pin_oe  = dir_q;
  assign irq_lo  = |(sts_q[HALF-1:0] & msk_q[HALF-1:0]);
  assign irq_hi  = |(sts_q[NPINS-1:HALF] & msk_q[NPINS-1:HALF]);
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk #(
  parameter int NPINS = 32,
  parameter int AW    = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_sel,
  input logic             bus_we,
  input logic [AW-1:0]    bus_addr,
  input logic [NPINS-1:0] bus_wdata,
  input logic [NPINS-1:0] pin_out,
  input logic [NPINS-1:0] pin_oe,
  input logic             irq_lo,
  input logic             irq_hi,
  input logic [NPINS-1:0] status_q,
  input logic [NPINS-1:0] mask_q
);
  logic wr_data, wr_dir, wr_sts;
  assign wr_data = bus_sel && bus_we && bus_addr[AW-1:2] == 3'd0;
  assign wr_dir  = bus_sel && bus_we && bus_addr[AW-1:2] == 3'd1;
  assign wr_sts  = bus_sel && bus_we && bus_addr[AW-1:2] == 3'd6;

  always @(negedge clk)
    if (!rst_n)
      p_reset_state_r1: assert (pin_out == '0 && pin_oe == '0 && !irq_lo && !irq_hi && status_q == '0);

  p_data_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data |=> pin_out == $past(bus_wdata));

  p_dir_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir |=> pin_oe == $past(bus_wdata));

  p_sticky_events_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_sts |=> (status_q & $past(status_q)) == $past(status_q));

  p_mask_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mask_q == '0 |-> (!irq_lo && !irq_hi));
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NPINS(NPINS), .AW(AW)) i_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .pin_out(pin_out),
  .pin_oe(pin_oe), .irq_lo(irq_lo), .irq_hi(irq_hi),
  .status_q(sts_q), .mask_q(msk_q)
);

// File: tb/test_gpio_irq_ctrl.sv
module test_gpio_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata, pad_in = '0, pin_out, pin_oe;
  logic        irq_lo, irq_hi;
  int          n_chk = 0, n_fail = 0;
  logic [31:0] v;

  always #10 clk = ~clk;

  gpio_irq_ctrl i_gpio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .irq_lo(irq_lo), .irq_hi(irq_hi)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic set_cfg(input int pin, input int code);
    logic [31:0] lo, hi;
    lo = '0; hi = '0;
    if (pin < 16) lo = 32'(code) << (2 * pin);
    else          hi = 32'(code) << (2 * (pin - 16));
    wr(5'h0C, lo);
    wr(5'h10, hi);
  endtask

  task automatic ev_bit(input string tag, input int pin, input logic exp);
    rd(5'h18, v);
    check(tag, {31'd0, v[pin]}, {31'd0, exp});
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (2) @(negedge clk);
    for (int a = 0; a < 32; a += 4) begin
      rd(5'(a), v);
      check("R1 reset register", v, 32'h0);
    end
    check("R1 reset pin_out", pin_out, 0);
    check("R1 reset pin_oe", pin_oe, 0);
    check("R1 reset irq", {30'd0, irq_hi, irq_lo}, 0);
    @(negedge clk);
    rst_n = 1'b1;

    wr(5'h00, 32'hDEADBEEF);
    rd(5'h00, v);
    check("R2 data readback", v, 32'hDEADBEEF);
    check("R2 pin_out", pin_out, 32'hDEADBEEF);
    wr(5'h04, 32'h0F0F00FF);
    rd(5'h04, v);
    check("R2 dir readback", v, 32'h0F0F00FF);
    check("R2 pin_oe", pin_oe, 32'h0F0F00FF);

    wr(5'h0C, 32'h1234ABCD);
    wr(5'h10, 32'h9876FEDC);
    rd(5'h0C, v); check("R4 cfg lo readback", v, 32'h1234ABCD);
    rd(5'h10, v); check("R4 cfg hi readback", v, 32'h9876FEDC);

    @(negedge clk);
    pad_in = 32'h12345678;
    @(negedge clk);
    rd(5'h08, v); check("R3 pad after one edge", v, 32'h0);
    @(negedge clk);
    rd(5'h08, v); check("R3 pad after two edges", v, 32'h12345678);
    pad_in = 32'h0;
    repeat (4) @(negedge clk);

    wr(5'h1C, 32'h0);
    for (int n = 0; n < 32; n++) begin
      for (int c = 0; c < 4; c++) begin
        set_cfg(n, c);
        wr(5'h18, 32'hFFFFFFFF);
        ev_bit($sformatf("R6 R8 pin %0d code %0d low clear", n, c), n, c == 0);
        pad_in[n] = 1'b1;
        repeat (3) @(negedge clk);
        ev_bit($sformatf("R4 R5 pin %0d code %0d rise", n, c), n, c != 3);
        wr(5'h18, 32'h1 << n);
        ev_bit($sformatf("R6 pin %0d code %0d high clear", n, c), n, c == 1);
        pad_in[n] = 1'b0;
        repeat (3) @(negedge clk);
        ev_bit($sformatf("R4 R5 pin %0d code %0d fall", n, c), n, c != 2);
        wr(5'h18, 32'h1 << n);
        ev_bit($sformatf("R6 pin %0d code %0d final clear", n, c), n, c == 0);
      end
    end

    for (int n = 0; n < 32; n++) begin
      set_cfg(n, 0);
      wr(5'h1C, 32'h1 << n);
      wr(5'h18, 32'hFFFFFFFF);
      ev_bit($sformatf("R7 pin %0d code ignored", n), n, 1'b0);
      pad_in[n] = 1'b1;
      repeat (3) @(negedge clk);
      ev_bit($sformatf("R7 pin %0d rise", n), n, 1'b1);
      wr(5'h18, 32'h1 << n);
      ev_bit($sformatf("R7 pin %0d cleared", n), n, 1'b0);
      pad_in[n] = 1'b0;
      repeat (3) @(negedge clk);
      ev_bit($sformatf("R7 pin %0d fall", n), n, 1'b1);
    end
    wr(5'h1C, 32'h0);

    wr(5'h0C, 32'hAAAAAAAA);
    wr(5'h10, 32'hAAAAAAAA);
    wr(5'h14, 32'h0);
    wr(5'h18, 32'hFFFFFFFF);
    pad_in = 32'hFFFFFFFF;
    repeat (3) @(negedge clk);
    rd(5'h18, v); check("R9 events with mask clear", v, 32'hFFFFFFFF);
    check("R10 mask zero irq", {30'd0, irq_hi, irq_lo}, 0);
    wr(5'h18, 32'h0000FFFF);
    rd(5'h18, v); check("R8 partial clear", v, 32'hFFFF0000);
    wr(5'h14, 32'h00000001);
    check("R10 low pin masked in, no event", {30'd0, irq_hi, irq_lo}, 0);
    wr(5'h14, 32'h00010000);
    check("R10 high half request", {30'd0, irq_hi, irq_lo}, 2);
    wr(5'h18, 32'hFFFF0000);
    check("R10 high half cleared", {30'd0, irq_hi, irq_lo}, 0);
    pad_in = 32'h0;
    repeat (3) @(negedge clk);
    pad_in = 32'hFFFFFFFF;
    repeat (3) @(negedge clk);
    wr(5'h14, 32'h00008000);
    check("R10 low half request", {30'd0, irq_hi, irq_lo}, 1);
    wr(5'h14, 32'h80008000);
    check("R10 both requests", {30'd0, irq_hi, irq_lo}, 3);

    finish_run();
  end
endmodule